// File: doc/BRIEF.md
# Alternating Read/Write Start Arbiter

This block sits in front of the core of a two-port memory that shares one address bus between a read port and a write port. On every rising edge of the input clock it samples two active-low port select lines. It then decides whether that edge starts a read burst, starts a write burst, or starts nothing. Only one start can be issued per edge. A burst occupies two cycles, so the arbiter also refuses a start of the same type as the one issued on the edge before.

When both ports request together, priority follows the previous decision instead of a fixed order. After an idle edge the read wins. After a read start the write wins. After a write start the read wins. So if both selects are held active from an idle state, the result is a strict alternation that begins with a read.

The decision is held in a three-state machine with the states IDLE, READ and WRITE. The state is the type of start issued on the most recent edge. The two start pulses and the last-operation code are decoded from it.

The transitions are:
- **both_idle**: IDLE to READ when both ports request.
- **both_after_rd**: READ to WRITE when both ports request.
- **both_after_wr**: WRITE to READ when both ports request.
- **rd_alone**: to READ from IDLE or WRITE when only the read port requests.
- **rd_blocked**: READ to IDLE when only the read port requests.
- **wr_alone**: to WRITE from IDLE or READ when only the write port requests.
- **wr_blocked**: WRITE to IDLE when only the write port requests.
- **no_req**: any state to IDLE when neither port requests.

Top module: `rw_start_arb`

## Requirements
- R1: `rd_start` and `wr_start` are never high in the same cycle.
- R2: When both selects are low at an edge and the previous edge issued no start, that edge issues a read start.
- R3: When both selects are low at an edge and the previous edge issued a read start, that edge issues a write start.
- R4: When both selects are low at an edge and the previous edge issued a write start, that edge issues a read start.
- R5: A lone read request issues a read start when the previous edge issued no read start. A lone write request issues a write start when the previous edge issued no write start.
- R6: A lone request of the same type as the start issued on the previous edge is dropped, so that edge issues no start.
- R7: Selects are sampled only at the rising clock edge. A start pulse appears right after the edge that decided it and lasts exactly one cycle. With both selects high, no start is issued.
- R8: `last_op` encodes the start issued at the most recent edge: 2'b00 for none, 2'b01 for read, 2'b10 for write.
- R9: Reset is active-low and asynchronous. It forces `last_op` to 2'b00 and keeps both starts low while it is asserted, whatever the selects do.
- R10: Holding both selects low, starting from the idle state, gives read, write, read, write and so on, one start per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Positive input clock; all decisions are taken at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read port select, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| rd_start | output | 1 | One-cycle pulse: a read burst starts |
| wr_start | output | 1 | One-cycle pulse: a write burst starts |
| last_op | output | 2 | Code of the start issued at the last edge (00 none, 01 read, 10 write) |

## Verification
Every result is due one edge after its stimulus. The selects seen at a rising edge set `rd_start`, `wr_start` and `last_op` immediately after that same edge, because there is exactly one register on the path. Reset is the exception: it clears the outputs at once, without waiting for an edge. The bench changes the selects at the falling edge and steps a reference model at the same moment. It samples the outputs at the following falling edge, half a period after the deciding edge. For the reset checks it samples a nanosecond after `rst_n` falls.

// File: rtl/rw_start_arb_pkg.sv
package rw_start_arb_pkg;

    // Type of start issued at the most recent clock edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10
    } op_e;

    localparam int OP_W = $bits(op_e);

endpackage

// File: rtl/rw_start_arb_next.sv
// Next-decision logic: picks the start for this edge from the requests
// and the start issued on the previous edge.
module rw_start_arb_next
    import rw_start_arb_pkg::*;
(
    input  op_e  cur_op,
    input  logic rd_req,
    input  logic wr_req,
    output op_e  nxt_op
);

    always_comb begin
        nxt_op = OP_IDLE;                          // no_req
        unique case (cur_op)
            OP_IDLE: begin
                if (rd_req)      nxt_op = OP_READ;  // both_idle / rd_alone
                else if (wr_req) nxt_op = OP_WRITE; // wr_alone
            end
            OP_READ: begin
                if (wr_req)      nxt_op = OP_WRITE; // both_after_rd / wr_alone
                else             nxt_op = OP_IDLE;  // rd_blocked / no_req
            end
            OP_WRITE: begin
                if (rd_req)      nxt_op = OP_READ;  // both_after_wr / rd_alone
                else             nxt_op = OP_IDLE;  // wr_blocked / no_req
            end
            default:             nxt_op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/rw_start_arb_state.sv
// State register holding the type of start issued at the last edge.
module rw_start_arb_state
    import rw_start_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  nxt_op,
    output op_e  cur_op
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_op <= OP_IDLE;
        else        cur_op <= nxt_op;
    end

endmodule

// File: rtl/rw_start_arb_outdec.sv
// Output decode: start pulses and last-operation code from the state.
module rw_start_arb_outdec
    import rw_start_arb_pkg::*;
(
    input  op_e              cur_op,
    output logic             rd_start,
    output logic             wr_start,
    output logic [OP_W-1:0]  last_op
);

    always_comb begin
        rd_start = 1'b0;
        wr_start = 1'b0;
        unique case (cur_op)
            OP_IDLE:  ;
            OP_READ:  rd_start = 1'b1;
            OP_WRITE: wr_start = 1'b1;
            default:  ;
        endcase
        last_op = cur_op;
    end

endmodule

// File: rtl/rw_start_arb.sv
// Alternating read/write start arbiter, top level.
module rw_start_arb
    import rw_start_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_sel_n,
    input  logic       wr_sel_n,
    output logic       rd_start,
    output logic       wr_start,
    output logic [1:0] last_op
);

    logic rd_req;
    logic wr_req;
    op_e  cur_op;
    op_e  nxt_op;

    assign rd_req = ~rd_sel_n;
    assign wr_req = ~wr_sel_n;

    rw_start_arb_next u_next (
        .cur_op (cur_op),
        .rd_req (rd_req),
        .wr_req (wr_req),
        .nxt_op (nxt_op)
    );

    rw_start_arb_state u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_op (nxt_op),
        .cur_op (cur_op)
    );

    rw_start_arb_outdec u_outdec (
        .cur_op   (cur_op),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .last_op  (last_op)
    );

endmodule

// File: rtl/rw_start_arb_chk.sv
// Property checker for the start arbiter, attached by bind.
module rw_start_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_sel_n,
    input logic       wr_sel_n,
    input logic       rd_start,
    input logic       wr_start,
    input logic [1:0] last_op
);

    a_r1_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && wr_start));

    a_r2_idle_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_sel_n && !wr_sel_n && last_op == 2'b00) |=> rd_start);

    a_r3_after_read_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_sel_n && !wr_sel_n && last_op == 2'b01) |=> wr_start);

    a_r4_after_write_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_sel_n && !wr_sel_n && last_op == 2'b10) |=> rd_start);

    a_r6_no_back_to_back_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    a_r6_no_back_to_back_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);

    a_r7_no_request_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_n && wr_sel_n) |=> (!rd_start && !wr_start));

endmodule

bind rw_start_arb rw_start_arb_chk u_chk (.*);

// File: tb/rw_start_arb_tb.sv
module rw_start_arb_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_sel_n = 1'b1;
    logic       wr_sel_n = 1'b1;
    logic       rd_start;
    logic       wr_start;
    logic [1:0] last_op;

    int         n_checks = 0;
    int         n_fails = 0;
    logic [1:0] exp_op = 2'b00;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    rw_start_arb u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .last_op  (last_op)
    );

    // Reference decision from the requirements (R2..R7).
    function automatic logic [1:0] model(logic [1:0] prev, bit rq, bit wq);
        if (rq && wq) return (prev == 2'b01) ? 2'b10 : 2'b01;
        if (rq)       return (prev == 2'b01) ? 2'b00 : 2'b01;
        if (wq)       return (prev == 2'b10) ? 2'b00 : 2'b10;
        return 2'b00;
    endfunction

    function automatic string tag_of(logic [1:0] prev, bit rq, bit wq);
        if (rq && wq) return (prev == 2'b00) ? "R2" : (prev == 2'b01) ? "R3" : "R4";
        if (rq)       return (prev == 2'b01) ? "R6" : "R5";
        if (wq)       return (prev == 2'b10) ? "R6" : "R5";
        return "R7";
    endfunction

    task automatic check_val(string tag, logic [1:0] act, logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(string tag);
        check_val(tag, {wr_start, rd_start}, {exp_op == 2'b10, exp_op == 2'b01});
        check_val("R8", last_op, exp_op);
        check_val("R1", {1'b0, rd_start & wr_start}, 2'b00);
    endtask

    // Called at a falling edge: drive requests, step model, check after edge.
    task automatic step(bit rq, bit wq);
        string t;
        t = tag_of(exp_op, rq, wq);
        rd_sel_n = !rq;
        wr_sel_n = !wq;
        exp_op = model(exp_op, rq, wq);
        @(posedge clk);
        @(negedge clk);
        check_outputs(t);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);

        // R9: requests active while reset is held, no starts allowed
        rd_sel_n = 1'b0;
        wr_sel_n = 1'b0;
        repeat (3) @(negedge clk);
        check_outputs("R9");
        rst_n = 1'b1;

        // R10 / R2 / R3 / R4: both held from idle
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b1);
            check_val("R10", {1'b0, rd_start}, {1'b0, (i % 2) == 0});
        end

        // R7: no request
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        // R5 / R6: lone reads back to back
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // R5 / R6: lone writes back to back
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        // R5: read after write, write after read
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);

        // R7: a select pulse that misses the edge is not seen
        rd_sel_n = 1'b1;
        wr_sel_n = 1'b1;
        exp_op = model(exp_op, 1'b0, 1'b0);
        @(posedge clk);
        #3 rd_sel_n = 1'b0;
        #3 rd_sel_n = 1'b1;
        @(negedge clk);
        check_outputs("R7");

        // R9: asynchronous reset mid-run after a read start
        step(1'b1, 1'b0);
        #2 rst_n = 1'b0;
        #1;
        exp_op = 2'b00;
        check_outputs("R9");
        rd_sel_n = 1'b0;
        wr_sel_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_outputs("R9");
        rst_n = 1'b1;
        step(1'b1, 1'b1);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 3);
            step(r[0], r[1]);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R7: watchdog expired, actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule